// File: doc/BRIEF.md
# Adjustable PTP Time Counter

This block keeps a nanosecond time-of-day count for a network timestamping unit. Every pulse of an 8 ns reference tick adds a fixed 8 ns to a 40-bit nanosecond counter. Below that counter sits a 32-bit sub-nanosecond residue. A sign-magnitude rate word trims the rate. Each tick, its magnitude (units of 2^-32 ns) is added to or subtracted from the residue. A carry out of the residue adds one extra nanosecond, and a borrow removes one.

Software reaches the counter through a single-cycle strobe bus with a 4-bit word address and 32-bit data. A read of the residue word freezes a copy of the nanosecond count, so the low and high words read next are coherent with it. A write of the low word only stages data. The high-word write loads the whole nanosecond value at once and clears the residue. A halt bit in an auxiliary control word stops counting, and the timer comes out of reset halted.

To move the rate by p parts per billion, software writes a magnitude of (|p| << 26) / 1953125 and sets the sign bit when p is negative.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the nanosecond count, residue and rate word are 0, and the control word at address 4 reads 0x8000_0000 (halted).
- R2: While running with a zero rate word, each cycle with `tick` high adds exactly 8 to the count. A cycle with `tick` low leaves the count unchanged.
- R3: While bit 31 of the control word (address 4) is 1, ticks do not change the count. Writing 0 there resumes counting. Reads of address 4 return bit 31 only, with bits 30:0 zero.
- R4: With rate bit 31 = 0, each tick adds bits 30:0 of the rate word (address 3) to the residue modulo 2^32. A carry out makes that tick advance the count by 9 instead of 8.
- R5: With rate bit 31 = 1, each tick subtracts bits 30:0 from the residue modulo 2^32. A borrow makes that tick advance the count by 7 instead of 8.
- R6: The count is 40 bits and wraps modulo 2^40. A read of the high word (address 2) returns count bits 39:32 in data bits 7:0, with bits 31:8 zero.
- R7: A read of address 0 returns the live residue and freezes the count. Later reads of address 1 (count bits 31:0) and address 2 return that frozen value, even if the count has moved since.
- R8: A write to address 1 does not change the count. A write to address 2 loads the count with {wdata[7:0], staged low word} and clears the residue.
- R9: When a high-word write and a running tick fall in the same cycle, the loaded value is taken without the 8 ns step.
- R10: Writes to address 0 are ignored. The rate word reads back at address 3 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 8 ns reference tick enable |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tod_ns | output | 40 | Live nanosecond count |

## Verification
The tick path is tried with a zero rate word, which isolates the fixed 8 ns step. Positive trims of one quarter and of the full magnitude separate carry timing from residue wrap, while negative trims of one quarter and of one unit show the borrow taken on the very first tick from an empty residue. A load just below 2^40 shows the wrap. Separate sequences let ticks run between a residue read and the word reads that follow it, and make a high-word write collide with a tick, so a stale snapshot or a lost load priority shows up as a wrong value.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    // Word addresses on the register bus
    localparam int unsigned REG_RES = 0;  // sub-ns residue, freezes count on read
    localparam int unsigned REG_LO  = 1;  // count bits 31:0 (staged on write)
    localparam int unsigned REG_HI  = 2;  // count upper bits, loads on write
    localparam int unsigned REG_ADJ = 3;  // sign-magnitude rate trim
    localparam int unsigned REG_AUX = 4;  // bit 31 halts the timer
endpackage

// File: rtl/tod_trim_step.sv
module tod_trim_step #(
    parameter int FRAC_W = 32,
    parameter int MAG_W  = 31
) (
    input  logic [FRAC_W-1:0] res_in,
    input  logic [MAG_W-1:0]  mag,
    input  logic              subtract,
    output logic [FRAC_W-1:0] res_out,
    output logic              carry,
    output logic              borrow
);
    localparam int EXT_W = FRAC_W + 1;

    logic [EXT_W-1:0] mag_ext;
    logic [EXT_W-1:0] sum_w;
    logic [EXT_W-1:0] diff_w;

    always_comb begin
        mag_ext = {{(EXT_W-MAG_W){1'b0}}, mag};
        sum_w   = {1'b0, res_in} + mag_ext;
        diff_w  = {1'b0, res_in} - mag_ext;
        if (subtract) begin
            res_out = diff_w[FRAC_W-1:0];
            borrow  = diff_w[FRAC_W];
            carry   = 1'b0;
        end else begin
            res_out = sum_w[FRAC_W-1:0];
            carry   = sum_w[FRAC_W];
            borrow  = 1'b0;
        end
    end
endmodule

// File: rtl/tod_regbus.sv
module tod_regbus
    import ptp_tod_pkg::*;
#(
    parameter int NS_W   = 40,
    parameter int FRAC_W = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NS_W-1:0]   cur_ns,
    input  logic [FRAC_W-1:0] cur_res,
    output logic [DATA_W-1:0] adj_word,
    output logic              halt,
    output logic              load_en,
    output logic [NS_W-1:0]   load_ns
);
    localparam int HI_W = NS_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] adj;
        logic              halt;
        logic [DATA_W-1:0] stage_lo;
        logic [NS_W-1:0]   snap;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        load_en = 1'b0;
        load_ns = {bus_wdata[HI_W-1:0], s_q.stage_lo};
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(REG_LO):  s_d.stage_lo = bus_wdata;
                ADDR_W'(REG_HI):  load_en      = 1'b1;
                ADDR_W'(REG_ADJ): s_d.adj      = bus_wdata;
                ADDR_W'(REG_AUX): s_d.halt     = bus_wdata[DATA_W-1];
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(REG_RES): begin
                    s_d.snap  = cur_ns;
                    s_d.rdata = DATA_W'(cur_res);
                end
                ADDR_W'(REG_LO):  s_d.rdata = s_q.snap[DATA_W-1:0];
                ADDR_W'(REG_HI):  s_d.rdata = DATA_W'(s_q.snap[NS_W-1:DATA_W]);
                ADDR_W'(REG_ADJ): s_d.rdata = s_q.adj;
                ADDR_W'(REG_AUX): s_d.rdata = {s_q.halt, {(DATA_W-1){1'b0}}};
                default:          s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.halt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign adj_word  = s_q.adj;
    assign halt      = s_q.halt;

    // R6: reserved high bits of the high word always read as zero
    p_hi_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(REG_HI)) |=> (bus_rdata[DATA_W-1:HI_W] == '0));

    // R3: control word exposes only the halt bit
    p_aux_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(REG_AUX)) |=> (bus_rdata[DATA_W-2:0] == '0));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
    parameter int NS_W      = 40,
    parameter int FRAC_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int BASE_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NS_W-1:0]   tod_ns
);
    localparam int MAG_W = DATA_W - 1;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] res;
    } cnt_state_t;

    cnt_state_t c_d, c_q;

    logic [DATA_W-1:0] adj_word;
    logic              halt;
    logic              load_en;
    logic [NS_W-1:0]   load_ns;
    logic [FRAC_W-1:0] res_next;
    logic              carry;
    logic              borrow;
    logic              advance;

    tod_regbus #(
        .NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_ns(c_q.ns), .cur_res(c_q.res),
        .adj_word(adj_word), .halt(halt),
        .load_en(load_en), .load_ns(load_ns)
    );

    tod_trim_step #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_trim (
        .res_in(c_q.res),
        .mag(adj_word[MAG_W-1:0]),
        .subtract(adj_word[DATA_W-1]),
        .res_out(res_next),
        .carry(carry),
        .borrow(borrow)
    );

    assign advance = tick && !halt;

    always_comb begin
        c_d = c_q;
        if (load_en) begin
            c_d.ns  = load_ns;
            c_d.res = '0;
        end else if (advance) begin
            c_d.res = res_next;
            c_d.ns  = c_q.ns + NS_W'(BASE_STEP) + NS_W'(carry) - NS_W'(borrow);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign tod_ns = c_q.ns;

    // R3: halted timer holds its count
    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load_en) |=> (c_q.ns == $past(c_q.ns)));

    // R2: untrimmed tick advances by the base step
    p_base_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_en && adj_word == '0)
        |=> (c_q.ns - $past(c_q.ns) == NS_W'(BASE_STEP)));

    // R4: positive trim steps by base or base+1
    p_pos_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_en && !adj_word[DATA_W-1])
        |=> ((c_q.ns - $past(c_q.ns) == NS_W'(BASE_STEP)) ||
             (c_q.ns - $past(c_q.ns) == NS_W'(BASE_STEP + 1))));

    // R5: negative trim steps by base or base-1
    p_neg_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_en && adj_word[DATA_W-1])
        |=> ((c_q.ns - $past(c_q.ns) == NS_W'(BASE_STEP)) ||
             (c_q.ns - $past(c_q.ns) == NS_W'(BASE_STEP - 1))));

    // R8 / R9: a load wins and clears the residue
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (c_q.ns == $past(load_ns) && c_q.res == '0));
endmodule

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [39:0] tod_ns;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_tod_counter uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tod_ns(tod_ns)
    );

    typedef struct packed {
        logic [31:0] adj;
        logic [7:0]  n;
        logic [39:0] load;
        logic [39:0] exp_ns;
        logic [31:0] exp_res;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0000, 8'd5, 40'h12_3456_7800, 40'h12_3456_7828, 32'h0000_0000},
        '{32'h4000_0000, 8'd5, 40'h12_3456_7800, 40'h12_3456_7829, 32'h4000_0000},
        '{32'hC000_0000, 8'd3, 40'h12_3456_7800, 40'h12_3456_7817, 32'h4000_0000},
        '{32'h7FFF_FFFF, 8'd3, 40'h12_3456_7800, 40'h12_3456_7819, 32'h7FFF_FFFD},
        '{32'h8000_0001, 8'd2, 40'h12_3456_7800, 40'h12_3456_780F, 32'hFFFF_FFFE},
        '{32'h0000_0000, 8'd2, 40'hFF_FFFF_FFF8, 40'h00_0000_0008, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [39:0] snap_exp;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 tod_ns", tod_ns, 0);
        bus_read(4'd0, rd); check("R1 residue", rd, 0);
        bus_read(4'd1, rd); check("R1 low", rd, 0);
        bus_read(4'd3, rd); check("R1 rate", rd, 0);
        bus_read(4'd4, rd); check("R1 control", rd, 32'h8000_0000);

        // R3: halted ticks are ignored, run resumes, halt again
        run_ticks(5);
        check("R3 halted hold", tod_ns, 0);
        bus_write(4'd4, 32'h0000_0000);
        bus_read(4'd4, rd); check("R3 control run", rd, 0);
        run_ticks(2);
        check("R2 two ticks", tod_ns, 16);
        bus_write(4'd4, 32'hFFFF_FFFF);
        bus_read(4'd4, rd); check("R3 control bits", rd, 32'h8000_0000);
        run_ticks(3);
        check("R3 halt again", tod_ns, 16);

        // R7: snapshot on residue read, ticks continue before word reads
        bus_write(4'd4, 32'h0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd0; tick = 1'b1;
        snap_exp = tod_ns;
        @(negedge clk);
        bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        check("R2 live after four ticks", tod_ns, snap_exp + 32);
        bus_read(4'd1, rd); check("R7 low frozen", rd, snap_exp[31:0]);
        bus_read(4'd2, rd); check("R7 high frozen", rd, {24'h0, snap_exp[39:32]});
        bus_write(4'd4, 32'h8000_0000);

        // Vector table: rate trims and wrap (R2, R4, R5, R6)
        for (int i = 0; i < 6; i++) begin
            if (VECS[i].adj[31])           tag = "R5";
            else if (VECS[i].adj != 0)     tag = "R4";
            else if (i == 5)               tag = "R6";
            else                           tag = "R2";
            bus_write(4'd3, VECS[i].adj);
            bus_write(4'd1, VECS[i].load[31:0]);
            bus_write(4'd2, {24'h0, VECS[i].load[39:32]});
            bus_write(4'd4, 32'h0);
            run_ticks(int'(VECS[i].n));
            bus_write(4'd4, 32'h8000_0000);
            check({tag, " vec count"}, tod_ns, VECS[i].exp_ns);
            bus_read(4'd0, rd); check({tag, " vec residue"}, rd, VECS[i].exp_res);
            bus_read(4'd1, rd); check({tag, " vec low"}, rd, VECS[i].exp_ns[31:0]);
            bus_read(4'd2, rd); check({tag, " vec high"}, rd, {24'h0, VECS[i].exp_ns[39:32]});
        end

        // R9: load collides with a running tick
        bus_write(4'd4, 32'h0);
        bus_write(4'd1, 32'h0000_1000);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h5;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 load wins", tod_ns, 40'h05_0000_1000);
        @(negedge clk);
        tick = 1'b0;
        check("R9 next tick", tod_ns, 40'h05_0000_1008);
        bus_write(4'd4, 32'h8000_0000);

        // R10: residue writes ignored, rate reads back
        bus_write(4'd3, 32'h8000_0001);
        bus_write(4'd4, 32'h0);
        run_ticks(1);
        bus_write(4'd4, 32'h8000_0000);
        bus_write(4'd0, 32'h1234_5678);
        bus_read(4'd0, rd); check("R10 residue write ignored", rd, 32'hFFFF_FFFF);
        bus_read(4'd3, rd); check("R10 rate readback", rd, 32'h8000_0001);
        check("R5 borrow from empty", tod_ns, 40'h05_0000_100F);

        // R8: staging and residue clear
        bus_write(4'd1, 32'hAAAA_5555);
        check("R8 low write staged", tod_ns, 40'h05_0000_100F);
        bus_write(4'd2, 32'h0000_003C);
        check("R8 high write loads", tod_ns, 40'h3C_AAAA_5555);
        bus_read(4'd0, rd); check("R8 residue cleared", rd, 0);

        // R6: reserved bits of high word
        bus_write(4'd2, 32'hFFFF_FFFF);
        bus_read(4'd0, rd);
        bus_read(4'd2, rd); check("R6 high reserved zero", rd, 32'h0000_00FF);
        check("R6 loaded top byte", tod_ns, 40'hFF_AAAA_5555);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule